// File: doc/BRIEF.md
# Binary-Weighted Programmable Byte Delay Line

This block delays a byte-wide sample stream by a programmable number of clock-enabled cycles, from 0 to 63. The delay is built from six plain shift-register sections. Their lengths are powers of two. The longest section (32 stages) sits nearest the input and the single-stage section sits nearest the output. Behind each section sits a two-way selector. It either forwards the section's last stage or routes the section's own input straight past it. The delay is therefore the sum of the lengths of the selected sections.

A setting of zero bypasses every section. The output is then the input itself through a chain of selectors, with no register on the way, so the block adds zero latency in that case. Every section shifts on each enabled clock, whether it is selected or not. A new setting changes the routing at once. The output may carry samples from the old routing until the newly selected path has filled.

Top module: `tapped_delay_line`

## Requirements
- R1: An active-low reset clears every stage to zero. While reset is asserted, and after it is released until real data has reached the output, the output reads 8'h00 for any nonzero setting.
- R2: With a setting of 0 the output equals the input in the same cycle, with no clock edge needed.
- R3: With a setting of 1 held steady, the output equals the input sampled at the previous enabled clock.
- R4: While the clock enable is low, no stage shifts. With the setting held, the output stays constant even if the input changes.
- R5: Once a setting D (an unsigned 6-bit value, 0 to 63) has been held for at least 63 enabled clocks, the output equals the input accepted D enabled clocks earlier.
- R6: Bit k of the setting selects the section of 2^k stages. Sections are ordered from longest at the input to shortest at the output, and composite settings delay by the sum of their bit weights.
- R7: All sections shift on every enabled clock, even when bypassed. After a long run at setting 0, switching to a single section of length L gives, on the very next output, the input accepted L enabled clocks earlier.
- R8: A setting change made while the clock enable is low reroutes the output immediately through the frozen stage contents.
- R9: The largest setting, 63, places all six sections in the path and delays by 63 enabled clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; clears all stages |
| clk_en | input | 1 | Shift enable; when low all stages hold |
| din | input | 8 | Input sample |
| dly_sel | input | 6 | Delay setting; bit k selects the 2^k-stage section |
| dout | output | 8 | Delayed sample |

## Verification
A change of delay setting and a stalled clock enable can land in the same cycle. The output must then be rerouted through stage contents that are not moving. The bench provokes this after a long run at setting 0. In one cycle it drops the enable, selects the 4-stage section and changes the input. It then judges the output against its own record of accepted samples, indexed by the count of enabled edges only. Further stalled cycles must leave the output unchanged, and the first enabled edge afterwards must advance it by exactly one sample.

// File: rtl/tapped_delay_line.sv
module tapped_delay_line #(
  parameter int WIDTH = 8,
  parameter int NSEC  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [WIDTH-1:0] din,
  input  logic [NSEC-1:0]  dly_sel,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] tap [NSEC+1];

  assign tap[0] = din;

  for (genvar i = 0; i < NSEC; i++) begin : g_sec
    localparam int K   = NSEC - 1 - i;
    localparam int LEN = 1 << K;

    logic [WIDTH-1:0] sr [LEN];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int j = 0; j < LEN; j++) sr[j] <= '0;
      end else if (clk_en) begin
        sr[0] <= tap[i];
        for (int j = 1; j < LEN; j++) sr[j] <= sr[j-1];
      end
    end

    assign tap[i+1] = dly_sel[K] ? sr[LEN-1] : tap[i];
  end

  assign dout = tap[NSEC];

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_n) && dly_sel != '0) |-> (dout == '0));

  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_sel == '0) |-> (dout == din));

  p_unit_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clk_en) && dly_sel == NSEC'(1) && $past(dly_sel) == NSEC'(1))
      |-> (dout == $past(din)));

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(clk_en) && $stable(dly_sel) && $stable(din))
      |-> $stable(dout));

endmodule

// File: tb/tapped_delay_line_tb_top.sv
module tapped_delay_line_tb_top;
  localparam int CLK_P = 10;
  localparam int NV    = 12;
  localparam logic [5:0] VSEL [NV] = '{6'd0, 6'd1, 6'd2, 6'd3, 6'd5, 6'd8,
                                       6'd16, 6'd21, 6'd32, 6'd42, 6'd63, 6'd37};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b0;
  logic [7:0] din = '0;
  logic [5:0] dly_sel = '0;
  logic [7:0] dout;

  int vecs = 0;
  int errs = 0;
  int cnt  = 0;
  int seq  = 0;
  bit done = 1'b0;
  logic [7:0] hist [8192];

  tapped_delay_line dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .din(din), .dly_sel(dly_sel), .dout(dout)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] nxt();
    seq++;
    return 8'(seq * 73 + (seq >> 2) + 5);
  endfunction

  function automatic logic [7:0] model(int d);
    if (d == 0) return din;
    if (cnt < d) return 8'h00;
    return hist[cnt - d];
  endfunction

  task automatic check(string req, logic [7:0] exp);
    vecs++;
    if (dout !== exp) begin
      errs++;
      $display("FAIL %s: dout=%h expected=%h (sel=%0d)", req, dout, exp, dly_sel);
    end
  endtask

  task automatic drive(logic [7:0] d, logic e);
    din = d;
    clk_en = e;
    @(posedge clk);
    if (e) begin
      hist[cnt] = d;
      cnt++;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errs++;
    $display("FAIL watchdog (all R): actual=hung expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state and early output
    dly_sel = 6'd63;
    repeat (3) @(negedge clk);
    check("R1", 8'h00);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      drive(nxt(), 1'b1);
      check("R1", 8'h00);
    end

    // R5/R6/R3/R9 vector table, with stalls during the checks (R4)
    for (int v = 0; v < NV; v++) begin
      dly_sel = VSEL[v];
      repeat (64) drive(nxt(), 1'b1);
      for (int k = 0; k < 8; k++) begin
        drive(nxt(), (k % 3) != 2);
        if (VSEL[v] == 6'd1)       check("R3", model(1));
        else if (VSEL[v] == 6'd63) check("R9", model(63));
        else if (VSEL[v] == 6'd0)  check("R2", model(0));
        else                       check("R5/R6", model(int'(VSEL[v])));
      end
    end

    // R2: combinational pass-through
    dly_sel = 6'd0;
    din = 8'h3C; #1; check("R2", 8'h3C);
    din = 8'hC3; #1; check("R2", 8'hC3);
    @(negedge clk);

    // R4: stalled clock holds the output against input changes
    dly_sel = 6'd5;
    repeat (64) drive(nxt(), 1'b1);
    for (int i = 0; i < 3; i++) begin
      drive(8'hA5 ^ 8'(i), 1'b0);
      check("R4", model(5));
    end

    // R7: bypassed sections keep shifting
    dly_sel = 6'd0;
    repeat (70) drive(nxt(), 1'b1);
    dly_sel = 6'd8; #1; check("R7", model(8));
    dly_sel = 6'd0;
    repeat (70) drive(nxt(), 1'b1);
    dly_sel = 6'd32; #1; check("R7", model(32));
    @(negedge clk);

    // R8: setting change in the same cycle as a stall
    dly_sel = 6'd0;
    repeat (70) drive(nxt(), 1'b1);
    clk_en = 1'b0;
    dly_sel = 6'd4;
    din = 8'h5A;
    #1; check("R8", model(4));
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      drive(nxt(), 1'b0);
      check("R8", model(4));
    end
    drive(nxt(), 1'b1);
    check("R8", model(4));

    // R1: reset in mid-stream
    dly_sel = 6'd63;
    clk_en = 1'b0;
    rst_n = 1'b0;
    #1; check("R1", 8'h00);
    @(negedge clk);
    cnt = 0;
    rst_n = 1'b1;
    #1; check("R1", 8'h00);
    @(negedge clk);
    drive(nxt(), 1'b1);
    check("R1", 8'h00);

    finish_run();
  end
endmodule